// File: doc/BRIEF.md
# Sleep-Mode Clock and Reset Controller

This block sits beside a small 8-bit microcontroller core and decides which clocks run. It divides the raw oscillator input by two and drives two gated outputs, one for the CPU and one for the peripherals (RAM, timers, serial port, interrupt logic). It also drives an enable that starts and stops the oscillator. A modulo-12 phase counter marks machine-cycle boundaries, one every 12 oscillator periods.

Software picks a low-power mode by writing two request bits, one for idle and one for power-down. Idle stops only the CPU clock, and any active interrupt request brings the core back. Power-down halts the oscillator, so every clock stops and all state is held. The only way out of power-down is the reset pin. That pin is synchronised first. It becomes an internal reset only after it has stayed high across two complete machine cycles of running oscillator. The internal reset also clears the mode and the request bits.

Top module: `pm_clk_ctrl`

## Requirements
- R1: While the oscillator runs, `per_clk_o` is the oscillator divided by two. Every high pulse lasts exactly one oscillator period and alternates with one low period. In run mode `cpu_clk_o` is identical to it.
- R2: `mc_tick_o` is high for one oscillator period out of every 12 while the oscillator runs.
- R3: A write in run mode with `idle_bit_i`=1 and `pd_bit_i`=0 sets `mode_o` to 2'b01 on the next edge. After that, `cpu_clk_o` gives no further high pulse while `per_clk_o` and `osc_en_o` keep running.
- R4: In idle (`mode_o`=2'b01), any nonzero `irq_i` at a clock edge returns `mode_o` to 2'b00 and clears the request. The CPU clock then resumes. In run mode an interrupt has no effect on the mode.
- R5: A write with `pd_bit_i`=1 sets `mode_o` to 2'b10 on the next edge, and `osc_en_o` drops at once. Both clocks then stay low, and `mc_tick_o` stays low because the phase is frozen.
- R6: In power-down, `irq_i` is ignored: `mode_o` stays 2'b10 and `osc_en_o` stays low.
- R7: A single write with both request bits set enters power-down (2'b10), not idle.
- R8: `rst_i`... the reset pin `rst_pin_i` passes through a 2-flop synchroniser. `rst_o` rises on the third machine-cycle boundary seen with the synchronised pin high. This is 27 to 38 oscillator periods after the pin rises in run or idle mode. A pulse shorter than that never raises `rst_o`.
- R9: A qualified reset returns `mode_o` to 2'b00 one edge after `rst_o` rises. This holds from idle and from power-down. In power-down, a high synchronised pin re-enables `osc_en_o` so that the qualification can count.
- R10: `rst_o` stays high while the synchronised pin is high. It falls on the third edge after the pin goes low.
- R11: While `rst_ni` is low, both clocks, `rst_o` and `mc_tick_o` are low, `osc_en_o` is high and `mode_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| wr_i | input | 1 | Software write strobe for the request bits |
| idle_bit_i | input | 1 | Idle request bit written with `wr_i` |
| pd_bit_i | input | 1 | Power-down request bit written with `wr_i` |
| irq_i | input | IRQ_W | Enabled interrupt requests |
| cpu_clk_o | output | 1 | Gated CPU clock |
| per_clk_o | output | 1 | Gated peripheral clock |
| osc_en_o | output | 1 | Oscillator enable |
| rst_o | output | 1 | Qualified internal reset |
| mc_tick_o | output | 1 | Machine-cycle boundary strobe |
| mode_o | output | 2 | Current mode: 00 run, 01 idle, 10 power-down |

## Verification
The assertions assume that `wr_i`, the request bits and `irq_i` are synchronous to `osc_clk_i`. They also assume that writes only matter while the CPU clock is running. The reset pin is the only asynchronous input, and it reaches the logic only through the synchroniser. The stimulus changes every input on the falling edge and issues writes only in run mode. It holds the reset pin for both too-short and long-enough intervals in run, idle and power-down. It compares all outputs against a behavioural model on every cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_PD   = 2'b10
  } pm_mode_e;
endpackage

// File: rtl/pm_phase_ctr.sv
module pm_phase_ctr #(
  parameter int MC_LEN = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  output logic ph_lsb_nxt_o,
  output logic tick_o
);
  localparam int PH_W = $clog2(MC_LEN);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_LEN - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    if (!osc_en_i)            ph_d = ph_q;
    else if (ph_q == PH_LAST) ph_d = '0;
    else                      ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign tick_o       = osc_en_i && (ph_q == PH_LAST);
  assign ph_lsb_nxt_o = ph_d[0];

  a_r2_wrap_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (ph_q == '0));
  a_r5_phase_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(ph_q));
endmodule

// File: rtl/pm_rst_qual.sv
module pm_rst_qual #(
  parameter int RST_MC      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic pin_s_o,
  output logic rst_o
);
  localparam int QW = $clog2(RST_MC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [QW-1:0]          cnt_q;
  logic                   rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end
  assign pin_s_o = sync_q[SYNC_STAGES-1];

  // first boundary opens a cycle; RST_MC more close RST_MC full cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (!pin_s_o) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (tick_i && !rst_q) begin
      if (cnt_q == QW'(RST_MC)) rst_q <= 1'b1;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end
  assign rst_o = rst_q;

  a_r8_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> ($past(tick_i) && $past(pin_s_o)));
  a_r10_drop_on_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_s_o |=> !rst_q);
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_pkg::*;
#(
  parameter int IRQ_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_i,
  input  logic             wr_i,
  input  logic             idle_bit_i,
  input  logic             pd_bit_i,
  input  logic [IRQ_W-1:0] irq_i,
  output pm_mode_e         mode_o,
  output logic             cpu_on_o
);
  pm_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_RUN;
    else if (rst_i) mode_q <= MODE_RUN;
    else begin
      case (mode_q)
        MODE_RUN: if (wr_i) begin
          if (pd_bit_i)        mode_q <= MODE_PD;   // power-down wins
          else if (idle_bit_i) mode_q <= MODE_IDLE;
        end
        MODE_IDLE: if (|irq_i) mode_q <= MODE_RUN;
        default: ;
      endcase
    end
  end

  assign mode_o   = mode_q;
  assign cpu_on_o = (mode_q == MODE_RUN);

  a_r9_rst_clears_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_i |=> (mode_q == MODE_RUN));
  a_r6_pd_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PD && !rst_i) |=> (mode_q == MODE_PD));
  a_r4_irq_wakes_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && |irq_i && !rst_i) |=> (mode_q == MODE_RUN));
  a_r7_pd_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && wr_i && pd_bit_i && !rst_i) |=> (mode_q == MODE_PD));
endmodule

// File: rtl/pm_clk_gen.sv
module pm_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic cpu_on_i,
  input  logic ph_lsb_nxt_i,
  output logic cpu_clk_o,
  output logic per_clk_o
);
  localparam int N_CLK = 2;  // 0: cpu, 1: peripheral

  logic [N_CLK-1:0] en, clk_q;
  assign en = {osc_en_i, osc_en_i & cpu_on_i};

  // registered outputs: a gate change never truncates a high pulse
  for (genvar g = 0; g < N_CLK; g++) begin : g_clk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) clk_q[g] <= 1'b0;
      else         clk_q[g] <= en[g] & ph_lsb_nxt_i;
    end
  end

  assign cpu_clk_o = clk_q[0];
  assign per_clk_o = clk_q[1];

  a_r5_clocks_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> (clk_q == '0));
  a_r3_cpu_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_on_i |=> !clk_q[0]);
  a_r1_single_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_q[1] |=> !clk_q[1]);
endmodule

// File: rtl/pm_clk_ctrl.sv
module pm_clk_ctrl
  import pm_pkg::*;
#(
  parameter int MC_LEN      = 12,
  parameter int RST_MC      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_W       = 5
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic             rst_pin_i,
  input  logic             wr_i,
  input  logic             idle_bit_i,
  input  logic             pd_bit_i,
  input  logic [IRQ_W-1:0] irq_i,
  output logic             cpu_clk_o,
  output logic             per_clk_o,
  output logic             osc_en_o,
  output logic             rst_o,
  output logic             mc_tick_o,
  output logic [1:0]       mode_o
);
  pm_mode_e mode;
  logic     cpu_on, pin_s, osc_en, ph_lsb_nxt, tick, int_rst;

  // pin restarts the oscillator so qualification can count
  assign osc_en = (mode != MODE_PD) | pin_s;

  pm_phase_ctr #(.MC_LEN(MC_LEN)) u_phase (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .osc_en_i(osc_en),
    .ph_lsb_nxt_o(ph_lsb_nxt), .tick_o(tick)
  );

  pm_rst_qual #(.RST_MC(RST_MC), .SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .pin_i(rst_pin_i), .tick_i(tick),
    .pin_s_o(pin_s), .rst_o(int_rst)
  );

  pm_mode_fsm #(.IRQ_W(IRQ_W)) u_mode (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .rst_i(int_rst), .wr_i(wr_i),
    .idle_bit_i(idle_bit_i), .pd_bit_i(pd_bit_i), .irq_i(irq_i),
    .mode_o(mode), .cpu_on_o(cpu_on)
  );

  pm_clk_gen u_clk (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .osc_en_i(osc_en), .cpu_on_i(cpu_on),
    .ph_lsb_nxt_i(ph_lsb_nxt), .cpu_clk_o(cpu_clk_o), .per_clk_o(per_clk_o)
  );

  assign osc_en_o  = osc_en;
  assign rst_o     = int_rst;
  assign mc_tick_o = tick;
  assign mode_o    = mode;
endmodule

// File: tb/pm_clk_ctrl_tb.sv
`timescale 1ns/100ps
module pm_clk_ctrl_tb;
  localparam int IRQ_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic rst_pin = 1'b0, wr = 1'b0, idle_b = 1'b0, pd_b = 1'b0;
  logic [IRQ_W-1:0] irq = '0;
  logic cpu_clk, per_clk, osc_en, rst_o, tick;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  pm_clk_ctrl #(.IRQ_W(IRQ_W)) u_dut (
    .osc_clk_i(clk), .rst_ni(rst_ni), .rst_pin_i(rst_pin), .wr_i(wr),
    .idle_bit_i(idle_b), .pd_bit_i(pd_b), .irq_i(irq),
    .cpu_clk_o(cpu_clk), .per_clk_o(per_clk), .osc_en_o(osc_en),
    .rst_o(rst_o), .mc_tick_o(tick), .mode_o(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: mode 0 run, 1 idle, 2 power-down
  int m_ph = 0, m_mode = 0, m_q = 0, m_r = 0, m_s1 = 0, m_s2 = 0;
  int m_cclk = 0, m_pclk = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_mode = 0; m_q = 0; m_r = 0; m_s1 = 0; m_s2 = 0;
      m_cclk = 0; m_pclk = 0;
    end else begin : step
      int run_osc, tk, nph, old_r, old_s2, old_mode;
      old_r = m_r; old_s2 = m_s2; old_mode = m_mode;
      run_osc = (old_mode != 2 || old_s2 != 0) ? 1 : 0;
      tk = (run_osc != 0 && m_ph == 11) ? 1 : 0;
      nph = (run_osc != 0) ? (m_ph + 1) % 12 : m_ph;
      m_cclk = (old_mode == 0 && run_osc != 0 && nph % 2 == 1) ? 1 : 0;
      m_pclk = (run_osc != 0 && nph % 2 == 1) ? 1 : 0;
      m_ph = nph;
      if (old_s2 == 0) begin m_q = 0; m_r = 0; end
      else if (tk != 0 && old_r == 0) begin
        if (m_q == 2) m_r = 1; else m_q++;
      end
      if (old_r != 0) m_mode = 0;
      else if (old_mode == 1 && irq != 0) m_mode = 0;
      else if (old_mode == 0 && wr) m_mode = pd_b ? 2 : (idle_b ? 1 : 0);
      m_s2 = m_s1; m_s1 = int'(rst_pin);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_ni) begin : cmp
      int e_osc;
      e_osc = (m_mode != 2 || m_s2 != 0) ? 1 : 0;
      chk("R1 per_clk", int'(per_clk), m_pclk);
      chk("R3 cpu_clk", int'(cpu_clk), m_cclk);
      chk("R5 osc_en", int'(osc_en), e_osc);
      chk("R2 mc_tick", int'(tick), (e_osc != 0 && m_ph == 11) ? 1 : 0);
      chk("R8 rst_o", int'(rst_o), m_r);
      chk("R4 mode", int'(mode), m_mode);
    end
  end

  task automatic run_n(input int n, output int c_hi, output int p_hi, output int tk);
    c_hi = 0; p_hi = 0; tk = 0;
    repeat (n) begin
      @(negedge clk);
      c_hi += int'(cpu_clk); p_hi += int'(per_clk); tk += int'(tick);
    end
  endtask

  task automatic sw_write(input logic id, input logic pd);
    wr = 1'b1; idle_b = id; pd_b = pd;
    @(negedge clk);
    wr = 1'b0; idle_b = 1'b0; pd_b = 1'b0;
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int c, p, t, k;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cpu_clk", int'(cpu_clk), 0);
    chk("R11 per_clk", int'(per_clk), 0);
    chk("R11 osc_en", int'(osc_en), 1);
    chk("R11 rst_o", int'(rst_o), 0);
    chk("R11 mode", int'(mode), 0);
    chk("R11 mc_tick", int'(tick), 0);
    rst_ni = 1'b1;
    cmp_on = 1'b1;

    // R1 R2 run mode
    run_n(48, c, p, t);
    chk("R1 per highs", p, 24);
    chk("R1 cpu highs", c, 24);
    chk("R2 ticks", t, 4);

    // R4: irq in run has no effect
    irq = 5'b00010; @(negedge clk); irq = '0;
    chk("R4 run irq ignored", int'(mode), 0);

    // R3 idle
    sw_write(1'b1, 1'b0);
    chk("R3 mode idle", int'(mode), 1);
    run_n(24, c, p, t);
    chk("R3 cpu stopped", c, 0);
    chk("R3 per running", p, 12);
    chk("R3 ticks in idle", t, 2);
    chk("R3 osc_en", int'(osc_en), 1);

    // R4 wake
    irq = 5'b00100; @(negedge clk); irq = '0;
    chk("R4 woke", int'(mode), 0);
    run_n(24, c, p, t);
    chk("R4 cpu resumes", c, 12);

    // R7 both bits, R5 power-down
    sw_write(1'b1, 1'b1);
    chk("R7 pd wins", int'(mode), 2);
    chk("R5 osc_en low", int'(osc_en), 0);
    run_n(30, c, p, t);
    chk("R5 cpu quiet", c, 0);
    chk("R5 per quiet", p, 0);
    chk("R5 tick quiet", t, 0);

    // R6 irq ignored in power-down
    irq = '1; @(negedge clk); irq = '0;
    run_n(3, c, p, t);
    chk("R6 mode held", int'(mode), 2);
    chk("R6 osc_en held", int'(osc_en), 0);
    chk("R6 no clocks", c + p, 0);

    // R9 reset exits power-down
    rst_pin = 1'b1;
    run_n(50, c, p, t);
    chk("R9 rst_o from pd", int'(rst_o), 1);
    chk("R9 mode cleared pd", int'(mode), 0);
    chk("R9 osc_en", int'(osc_en), 1);

    // R10 release timing
    rst_pin = 1'b0;
    run_n(2, c, p, t);
    chk("R10 rst_o still high", int'(rst_o), 1);
    run_n(1, c, p, t);
    chk("R10 rst_o low", int'(rst_o), 0);
    run_n(5, c, p, t);

    // R8 qualification window, R9 reset exits idle
    sw_write(1'b1, 1'b0);
    chk("R3 idle again", int'(mode), 1);
    rst_pin = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!rst_o && k < 60);
    chk("R8 rise window", (k >= 27 && k <= 38) ? 1 : 0, 1);
    @(negedge clk);
    chk("R9 mode cleared idle", int'(mode), 0);
    rst_pin = 1'b0;
    run_n(6, c, p, t);

    // R8 short pulse rejected
    rst_pin = 1'b1;
    k = 0;
    repeat (14) begin @(negedge clk); k += int'(rst_o); end
    rst_pin = 1'b0;
    repeat (6) begin @(negedge clk); k += int'(rst_o); end
    chk("R8 short pulse", k, 0);

    // R5 pd from run with a fresh phase
    run_n(7, c, p, t);
    sw_write(1'b0, 1'b1);
    chk("R5 mode pd", int'(mode), 2);
    run_n(12, c, p, t);
    chk("R5 no clocks", c + p + t, 0);

    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule